// File: doc/BRIEF.md
# External Interrupt Edge/Level Detector

This block turns a group of input pins into one external interrupt request. The pins are active low. Each pin has its own enable bit. The enabled pins are merged into a single combined line, which is high only while every enabled pin is high. A two-bit polarity control then picks the kind of event on that combined line that raises the request: a low level, a rising edge, a falling edge, or either edge.

Edge events are held in a request flag. The flag clears by itself when the interrupt controller sends its acknowledge pulse, which marks entry into the service routine. In level mode the request is not stored: it simply follows the combined line while that line is low. Because polarity is judged on the merged line and not on each pin, a pin that is held low keeps the combined line low. This hides any rising edge coming from the other pins.

Top module: `exti_detector`

## Requirements
- R1: After reset the request output `irq_o` is 0. The synchroniser stages and the edge history start at the idle-high value, so releasing reset with all pins high produces no event.
- R2: The combined line is the AND of (pin OR NOT enable) over all pins. A pin whose enable bit is 0 has no effect on `irq_o`.
- R3: With polarity 2'b10 (falling only), a 1-to-0 transition of the combined line sets `irq_o` at the third rising clock edge after the pin change. Rising transitions do not set it.
- R4: With polarity 2'b01 (rising only), a 0-to-1 transition of the combined line sets `irq_o` at the third rising clock edge after the pin change. Falling transitions do not set it.
- R5: With polarity 2'b11 (both edges), either transition of the combined line sets `irq_o` at the third rising clock edge after the pin change.
- R6: With polarity 2'b00 (low level), `irq_o` equals the inverse of the synchronised combined line. It goes to 1 two clock edges after an enabled pin goes low, goes back to 0 two edges after the line returns high, and is never latched.
- R7: In the edge modes a set request stays at 1 until a clock edge at which `ack_i` is 1. At that edge it clears, unless R8 applies.
- R8: If a new edge event and `ack_i` meet on the same clock edge, the event wins and `irq_o` stays 1.
- R9: While any enabled pin is held low, rising edges on the other enabled pins produce no request in rising-edge mode. The request is raised only when the last low pin is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Detector clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | NUM_PINS | Raw active-low interrupt pins |
| pin_en_i | input | NUM_PINS | Per-pin enable mask, 1 = pin takes part in the combined line |
| polarity_i | input | 2 | Event select: 00 low level, 01 rising, 10 falling, 11 both |
| ack_i | input | 1 | Service-entry acknowledge, clears a latched request |
| irq_o | output | 1 | Interrupt request to the controller |

## Verification
Directed patterns drive a single enabled pin through each of the four polarity settings. These show that edges are judged per mode and that level mode does not hold its request. A second pin that is held low while the first one toggles shows that polarity is judged on the merged line (R9) and not per pin. Toggling a pin whose enable bit is clear shows that masking works. Lining up an acknowledge with a fresh falling edge shows that a new event has priority over clearing. A long random run then mixes pins, masks, modes and acknowledges against a cycle-level model kept in the bench.

// File: rtl/exti_pkg.sv
package exti_pkg;

  typedef enum logic [1:0] {
    POL_LOW_LEVEL = 2'b00,
    POL_RISE      = 2'b01,
    POL_FALL      = 2'b10,
    POL_BOTH      = 2'b11
  } pol_e;

  // Decide whether a transition of the combined line counts as an event
  function automatic logic edge_hit(pol_e pol, logic prev, logic cur);
    logic rise;
    logic fall;
    rise = ~prev & cur;
    fall = prev & ~cur;
    case (pol)
      POL_RISE: return rise;
      POL_FALL: return fall;
      POL_BOTH: return rise | fall;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/exti_rst_sync.sv
module exti_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/exti_sync.sv
module exti_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] stg_q;
    logic [STAGES-1:0] stg_d;

    always_comb begin
      stg_d = {stg_q[STAGES-2:0], d_i[b]};
    end

    // Idle-high reset value: pins are active low
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= '1;
      else         stg_q <= stg_d;
    end

    assign q_o[b] = stg_q[LAST];
  end
endmodule

// File: rtl/exti_combine.sv
module exti_combine #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] pin_s_i,
  input  logic [WIDTH-1:0] en_i,
  output logic             line_o
);
  logic [WIDTH-1:0] masked;

  always_comb begin
    masked = pin_s_i | ~en_i;
    line_o = &masked;
  end

  // R2: an empty enable mask leaves the line idle high
  always_comb begin
    a_no_enable_idle_r2: assert (!(en_i == '0) || line_o)
      else $error("combined line low with no enabled pin");
  end
endmodule

// File: rtl/exti_edge.sv
module exti_edge
  import exti_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  pol_e pol_i,
  output logic event_o,
  output logic level_req_o
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d      = line_i;
    event_o     = edge_hit(pol_i, prev_q, line_i);
    level_req_o = (pol_i == POL_LOW_LEVEL) & ~line_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= prev_d;
  end

  // R6: level mode never reports an edge event
  p_level_no_event_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_i == POL_LOW_LEVEL) |-> !event_o);

  // R3: falling-only mode fires only after the line was high one cycle ago
  p_fall_needs_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_i == POL_FALL && event_o) |-> (prev_q && !line_i));
endmodule

// File: rtl/exti_detector.sv
module exti_detector
  import exti_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] pin_en_i,
  input  logic [1:0]          polarity_i,
  input  logic                ack_i,
  output logic                irq_o
);
  logic                rst_n_int;
  logic [NUM_PINS-1:0] pin_s;
  logic                line;
  logic                evt;
  logic                lvl_req;
  logic                pend_q;
  logic                pend_d;
  logic                pend_en;
  pol_e                pol;

  assign pol = pol_e'(polarity_i);

  exti_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_int)
  );

  exti_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n_int),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  exti_combine #(.WIDTH(NUM_PINS)) u_comb (
    .pin_s_i(pin_s),
    .en_i   (pin_en_i),
    .line_o (line)
  );

  exti_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .line_i     (line),
    .pol_i      (pol),
    .event_o    (evt),
    .level_req_o(lvl_req)
  );

  // Pending flag: a new event beats the acknowledge
  always_comb begin
    pend_en = evt | ack_i;
    pend_d  = evt ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int)   pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign irq_o = (pol == POL_LOW_LEVEL) ? lvl_req : pend_q;

  // R7: an acknowledge without a competing event clears the flag
  p_ack_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (ack_i && !evt) |=> !pend_q);

  // R7: without an acknowledge the flag holds
  p_flag_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (pend_q && !ack_i) |=> pend_q);

  // R8: an event always leaves the flag set, acknowledge or not
  p_event_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    evt |=> pend_q);

  // R3: the flag only rises after an event
  p_no_spurious_r3: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    $rose(pend_q) |-> $past(evt));
endmodule

// File: tb/exti_detector_tb.sv
module exti_detector_tb_top;
  localparam int N = 8;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] pins;
  logic [N-1:0] pin_en;
  logic [1:0]   pol;
  logic         ack;
  logic         irq;

  int n_chk  = 0;
  int n_fail = 0;

  // bench reference state
  logic [N-1:0] m_s1, m_s2;
  logic         m_prev, m_latch;

  exti_detector #(.NUM_PINS(N)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .pin_i     (pins),
    .pin_en_i  (pin_en),
    .polarity_i(pol),
    .ack_i     (ack),
    .irq_o     (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic line_of(logic [N-1:0] s, logic [N-1:0] m);
    return &(s | ~m);
  endfunction

  function automatic logic hit(logic [1:0] p, logic pv, logic c);
    case (p)
      2'b01:   return ~pv & c;
      2'b10:   return pv & ~c;
      2'b11:   return pv ^ c;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_req();
    return (pol == 2'b00) ? ~line_of(m_s2, pin_en) : m_latch;
  endfunction

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      logic c, e;
      @(posedge clk);
      c       = line_of(m_s2, pin_en);
      e       = hit(pol, m_prev, c);
      m_latch = e ? 1'b1 : (ack ? 1'b0 : m_latch);
      m_prev  = c;
      m_s2    = m_s1;
      m_s1    = pins;
      @(negedge clk);
    end
  endtask

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (irq !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_o=%0b expected %0b at %0t", req, irq, exp, $time);
    end
  endtask

  task automatic pulse_ack();
    ack = 1'b1; cyc(1); ack = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    pins = '1; pin_en = 8'h01; pol = 2'b10; ack = 1'b0; rst_n = 1'b0;
    m_s1 = '1; m_s2 = '1; m_prev = 1'b1; m_latch = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(4);
    check(1'b0, "R1");

    // R3 falling edge, latency and hold
    pins[0] = 1'b0; cyc(2); check(1'b0, "R3");
    cyc(1); check(1'b1, "R3");
    pins[0] = 1'b1; cyc(3); check(1'b1, "R7");
    pulse_ack(); check(1'b0, "R7");

    // R4 rising only
    pol = 2'b01;
    pins[0] = 1'b0; cyc(3); check(1'b0, "R4");
    pins[0] = 1'b1; cyc(3); check(1'b1, "R4");
    pulse_ack(); check(1'b0, "R4");

    // R9 held low pin masks rising edges of another pin
    pin_en = 8'h03;
    pins[1] = 1'b0; cyc(3);
    pins[0] = 1'b0; cyc(3); pins[0] = 1'b1; cyc(3); check(1'b0, "R9");
    pins[1] = 1'b1; cyc(3); check(1'b1, "R9");
    pulse_ack(); check(1'b0, "R9");

    // R2 disabled pin has no effect
    pin_en = 8'h01; pol = 2'b11;
    pins[5] = 1'b0; cyc(3); pins[5] = 1'b1; cyc(3); check(1'b0, "R2");

    // R5 both edges
    pins[0] = 1'b0; cyc(3); check(1'b1, "R5");
    pulse_ack(); check(1'b0, "R5");
    pins[0] = 1'b1; cyc(3); check(1'b1, "R5");
    pulse_ack(); check(1'b0, "R5");

    // R8 event coincides with acknowledge
    pol = 2'b10;
    pins[0] = 1'b0; cyc(3); check(1'b1, "R8");
    pins[0] = 1'b1; cyc(3);
    pins[0] = 1'b0; cyc(2);
    ack = 1'b1; cyc(1); ack = 1'b0; check(1'b1, "R8");
    pulse_ack(); check(1'b0, "R8");
    pins[0] = 1'b1; cyc(3);

    // R6 level mode follows the line, not latched
    pol = 2'b00;
    pins[0] = 1'b0; cyc(1); check(1'b0, "R6");
    cyc(1); check(1'b1, "R6");
    pins[0] = 1'b1; cyc(2); check(1'b0, "R6");

    // random mix against the bench model
    for (int k = 0; k < 4000; k++) begin
      string tag;
      if ($urandom % 3 == 0) pins = pins ^ (N'(1) << ($urandom % N));
      if ($urandom % 50 == 0) pin_en = N'($urandom);
      if ($urandom % 80 == 0) pol = 2'($urandom);
      ack = ($urandom % 6 == 0);
      cyc(1);
      case (pol)
        2'b00:   tag = "R6";
        2'b01:   tag = "R4";
        2'b10:   tag = "R3";
        default: tag = "R5";
      endcase
      check(exp_req(), tag);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule